// File: doc/BRIEF.md
# PCIe Host Interrupt Aggregator

This block gathers the interrupt events of a PCIe root-complex wrapper and turns them into a small set of level outputs for a host processor. It handles three kinds of source. The first is 32 message-signalled vectors, folded into eight groups of four. The second is four legacy INTx lines. The third is six error sources. Every source has a sticky status bit and an enable bit. The host reaches all of them through one 32-bit register port, with a write strobe and a combinational read.

The message vectors are interleaved across groups. Vector `v` lands in group `v mod 8`, at bit `v >> 3`. Each message group and each legacy line drives its own output. After servicing a group, software writes that group's code to a shared end-of-interrupt register. The output then falls for one cycle and rises again if anything is still pending, so the interrupt controller sees a fresh edge. Errors have two read views: a raw one and one masked by the enables. They drive a combined output and a separate output for the fatal class.

Top module: `pcie_irq_hub`

## Requirements
- R1: A pulse on message vector `v` sets bit `v >> 3` of the status register of group `g = v mod 8`. That register sits at byte address 0x104 + 16*g and holds the group in bits [3:0]. No other group's status changes.
- R2: Writing to a group status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: The enable-set register of group `g` is at 0x108 + 16*g and the enable-clear register is at 0x10C + 16*g. Writing 1 to a bit of the first sets that enable bit, and writing 1 to a bit of the second clears it. Reading either address returns the current enable mask.
- R4: `msi_irq[g]` is high exactly when group `g` is armed and has a status bit whose enable bit is also set. A pending bit that is not enabled leaves the output low.
- R5: Writing the value `g + 4` to the end-of-interrupt register at 0x050 disarms group `g` for one cycle. Its output is low in the cycle after the write and high again in the next cycle if the group is still pending. No other group is affected.
- R6: Legacy line `i` uses bit 0 of a status register at 0x184 + 16*i, an enable-set register at 0x188 + 16*i and an enable-clear register at 0x18C + 16*i. These follow the same set, clear and output rules as R1 to R4 on `intx_irq[i]`. Writing the value `i` to 0x050 re-arms the line in the same way as R5.
- R7: Error event `e` (bits 0 to 5) sets bit `e` of the raw error status at 0x1C0 whatever the enables hold. Address 0x1C4 reads the raw status ANDed with the error enable mask. The error enable-set register is at 0x1C8 and the error enable-clear register is at 0x1CC.
- R8: Writing to 0x1C4 clears each error bit written as 1. Writes to 0x1C0 have no effect.
- R9: `err_irq` is high while any enabled error bit is set, and it has no re-arm step. `err_fatal_irq` is high while enabled bit 1 or bit 4 is set.
- R10: When a source pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R11: After reset all status and enable bits are zero and every output is low. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| msi_hit | input | 32 | One-cycle event pulse per message vector |
| intx_hit | input | 4 | One-cycle event pulse per legacy line |
| err_hit | input | 6 | One-cycle event pulse per error source |
| msi_irq | output | 8 | Interrupt output per message group |
| intx_irq | output | 4 | Interrupt output per legacy line |
| err_irq | output | 1 | Any enabled error pending |
| err_fatal_irq | output | 1 | Enabled fatal-class error pending |

## Verification
The hardest situation to reach from the ports is the collision between an event and its own acknowledge. The pulse on `msi_hit` has to land in the same clock as the register write that clears that bit. The bench sets both up at the same falling edge and then reads the status back. The other delicate case is the one-cycle gap after an end-of-interrupt write. The bench samples the output at the two falling edges that follow the write, and expects low and then high while the group stays pending. The vector-to-group interleave is swept over all 32 vectors, reading back all eight groups for each one.

// File: rtl/pcie_irq_hub_pkg.sv
package pcie_irq_hub_pkg;

   // Error source bit positions (hardware decodes these)
   typedef enum int {
      ERRB_SYSTEM   = 0,
      ERRB_FATAL    = 1,
      ERRB_NONFATAL = 2,
      ERRB_CORR     = 3,
      ERRB_TAGLOOK  = 4,
      ERRB_ECRC     = 5
   } err_bit_e;

   // Vector to group / bit in the interleaved layout
   function automatic int vec_group(input int v, input int groups);
      return v % groups;
   endfunction

   function automatic int vec_slot(input int v, input int groups);
      return v / groups;
   endfunction

endpackage

// File: rtl/hub_irq_cell.sv
module hub_irq_cell #(
   parameter int WIDTH = 4,
   parameter bit REARM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src_pulse,
   input  logic [WIDTH-1:0] clr_w1c,
   input  logic [WIDTH-1:0] en_set,
   input  logic [WIDTH-1:0] en_clr,
   input  logic             eoi,
   output logic [WIDTH-1:0] status,
   output logic [WIDTH-1:0] enable,
   output logic             irq
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("hub_irq_cell: WIDTH must lie in 1..32");
   end

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~clr_w1c) | src_pulse;
         enable <= (enable & ~en_clr) | en_set;
      end
   end

   if (REARM) begin : g_rearm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     armed <= 1'b1;
         else if (eoi)   armed <= 1'b0;
         else            armed <= 1'b1;
      end

      // R5: output is low in the cycle after an end-of-interrupt
      assert_eoi_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         eoi |=> !irq);
   end else begin : g_level
      assign armed = 1'b1;
   end

   assign irq = armed & (|(status & enable));

   // R1: a status bit only rises after a source pulse
   assert_no_spurious_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(src_pulse)) == '0));

   // R2: a write-one clear without a pulse leaves the bit cleared
   assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_w1c & ~src_pulse) != '0) |=> ((status & $past(clr_w1c & ~src_pulse)) == '0));

   // R10: the set wins against a same-cycle clear
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_w1c & src_pulse) != '0) |=>
         ((status & $past(clr_w1c & src_pulse)) == $past(clr_w1c & src_pulse)));

   // R3: enable-clear with no matching set drops the enable bit
   assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_clr & ~en_set) != '0) |=> ((enable & $past(en_clr & ~en_set)) == '0));

endmodule

// File: rtl/pcie_irq_hub.sv
module pcie_irq_hub #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int MSI_VECS     = 32,
   parameter int MSI_GROUPS   = 8,
   parameter int INTX_LINES   = 4,
   parameter int ERR_BITS     = 6,
   parameter int STRIDE       = 16,
   parameter int MSI_BASE     = 'h104,
   parameter int INTX_BASE    = 'h184,
   parameter int ERR_BASE     = 'h1C0,
   parameter int EOI_ADDR     = 'h050,
   parameter int MSI_EOI_BASE = 4,
   parameter logic [ERR_BITS-1:0] FATAL_MASK = 6'b01_0010
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [MSI_VECS-1:0]   msi_hit,
   input  logic [INTX_LINES-1:0] intx_hit,
   input  logic [ERR_BITS-1:0]   err_hit,
   output logic [MSI_GROUPS-1:0] msi_irq,
   output logic [INTX_LINES-1:0] intx_irq,
   output logic                  err_irq,
   output logic                  err_fatal_irq
);
   import pcie_irq_hub_pkg::*;

   localparam int MSI_BITS = MSI_VECS / MSI_GROUPS;

   if (MSI_VECS % MSI_GROUPS != 0) begin : g_bad_split
      $error("pcie_irq_hub: MSI_VECS must divide evenly into MSI_GROUPS");
   end
   if (ERR_BITS > DATA_W || MSI_BITS > DATA_W) begin : g_bad_data
      $error("pcie_irq_hub: register fields exceed DATA_W");
   end

   logic wr_eoi;
   assign wr_eoi = reg_we && (reg_addr == ADDR_W'(EOI_ADDR));

   function automatic logic hit_at(input logic [ADDR_W-1:0] a, input int off);
      return reg_we && (a == ADDR_W'(off));
   endfunction

   logic [MSI_BITS-1:0]   msi_stat [MSI_GROUPS];
   logic [MSI_BITS-1:0]   msi_en   [MSI_GROUPS];
   logic [INTX_LINES-1:0] intx_stat, intx_en;
   logic [ERR_BITS-1:0]   err_stat, err_en;

   for (genvar g = 0; g < MSI_GROUPS; g++) begin : g_msi
      localparam int A = MSI_BASE + g * STRIDE;
      logic [MSI_BITS-1:0] hits;
      for (genvar k = 0; k < MSI_BITS; k++) begin : g_slot
         assign hits[k] = msi_hit[g + MSI_GROUPS * k];
      end
      hub_irq_cell #(.WIDTH(MSI_BITS), .REARM(1'b1)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_pulse (hits),
         .clr_w1c   (hit_at(reg_addr, A)     ? reg_wdata[MSI_BITS-1:0] : '0),
         .en_set    (hit_at(reg_addr, A + 4) ? reg_wdata[MSI_BITS-1:0] : '0),
         .en_clr    (hit_at(reg_addr, A + 8) ? reg_wdata[MSI_BITS-1:0] : '0),
         .eoi       (wr_eoi && (reg_wdata == DATA_W'(MSI_EOI_BASE + g))),
         .status    (msi_stat[g]),
         .enable    (msi_en[g]),
         .irq       (msi_irq[g])
      );
   end

   for (genvar i = 0; i < INTX_LINES; i++) begin : g_intx
      localparam int A = INTX_BASE + i * STRIDE;
      hub_irq_cell #(.WIDTH(1), .REARM(1'b1)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_pulse (intx_hit[i]),
         .clr_w1c   (hit_at(reg_addr, A)     & reg_wdata[0]),
         .en_set    (hit_at(reg_addr, A + 4) & reg_wdata[0]),
         .en_clr    (hit_at(reg_addr, A + 8) & reg_wdata[0]),
         .eoi       (wr_eoi && (reg_wdata == DATA_W'(i))),
         .status    (intx_stat[i]),
         .enable    (intx_en[i]),
         .irq       (intx_irq[i])
      );
   end

   hub_irq_cell #(.WIDTH(ERR_BITS), .REARM(1'b0)) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_pulse (err_hit),
      .clr_w1c   (hit_at(reg_addr, ERR_BASE + 4)  ? reg_wdata[ERR_BITS-1:0] : '0),
      .en_set    (hit_at(reg_addr, ERR_BASE + 8)  ? reg_wdata[ERR_BITS-1:0] : '0),
      .en_clr    (hit_at(reg_addr, ERR_BASE + 12) ? reg_wdata[ERR_BITS-1:0] : '0),
      .eoi       (1'b0),
      .status    (err_stat),
      .enable    (err_en),
      .irq       (err_irq)
   );

   assign err_fatal_irq = |(err_stat & err_en & FATAL_MASK);

   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < MSI_GROUPS; g++) begin
         if (reg_addr == ADDR_W'(MSI_BASE + g * STRIDE))
            reg_rdata = DATA_W'(msi_stat[g]);
         if (reg_addr == ADDR_W'(MSI_BASE + g * STRIDE + 4) ||
             reg_addr == ADDR_W'(MSI_BASE + g * STRIDE + 8))
            reg_rdata = DATA_W'(msi_en[g]);
      end
      for (int i = 0; i < INTX_LINES; i++) begin
         if (reg_addr == ADDR_W'(INTX_BASE + i * STRIDE))
            reg_rdata = DATA_W'(intx_stat[i]);
         if (reg_addr == ADDR_W'(INTX_BASE + i * STRIDE + 4) ||
             reg_addr == ADDR_W'(INTX_BASE + i * STRIDE + 8))
            reg_rdata = DATA_W'(intx_en[i]);
      end
      if (reg_addr == ADDR_W'(ERR_BASE))      reg_rdata = DATA_W'(err_stat);
      if (reg_addr == ADDR_W'(ERR_BASE + 4))  reg_rdata = DATA_W'(err_stat & err_en);
      if (reg_addr == ADDR_W'(ERR_BASE + 8) ||
          reg_addr == ADDR_W'(ERR_BASE + 12)) reg_rdata = DATA_W'(err_en);
   end

   // R9: the fatal output implies the combined error output
   assert_fatal_in_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_fatal_irq |-> err_irq);

   // R8: a write to the raw view never clears an error bit
   assert_raw_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_at(reg_addr, ERR_BASE) |=> ((err_stat & $past(err_stat)) == $past(err_stat)));

   // R11: with no enables there are no interrupt outputs
   assert_quiet_when_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (intx_en == '0) |-> (intx_irq == '0));

endmodule

// File: tb/pcie_irq_hub_test.sv
`timescale 1ns/1ps
module pcie_irq_hub_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] msi_hit = '0;
   logic [3:0]  intx_hit = '0;
   logic [5:0]  err_hit = '0;
   logic [7:0]  msi_irq;
   logic [3:0]  intx_irq;
   logic        err_irq, err_fatal_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pcie_irq_hub uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_hit(msi_hit),
      .intx_hit(intx_hit), .err_hit(err_hit), .msi_irq(msi_irq),
      .intx_irq(intx_irq), .err_irq(err_irq), .err_fatal_irq(err_fatal_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [31:0] m, input logic [3:0] ix, input logic [5:0] e);
      @(negedge clk);
      msi_hit = m; intx_hit = ix; err_hit = e;
      @(posedge clk);
      @(negedge clk);
      msi_hit = '0; intx_hit = '0; err_hit = '0;
   endtask

   function automatic logic [11:0] st_addr(input int g);
      return 12'(32'h104 + 16 * g);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      check("R11 msi_irq", 32'(msi_irq), 0);
      check("R11 intx_irq", 32'(intx_irq), 0);
      check("R11 err_irq", 32'({err_irq, err_fatal_irq}), 0);
      for (int g = 0; g < 8; g++) begin
         rd(st_addr(g), d);     check("R11 msi status", d, 0);
         rd(st_addr(g) + 4, d); check("R11 msi enable", d, 0);
      end
      rd(12'h1C0, d); check("R11 err raw", d, 0);
      rd(12'h000, d); check("R11 unmapped", d, 0);

      // R1 sweep + R2 full clear
      for (int v = 0; v < 32; v++) begin
         pulse(32'(1) << v, 0, 0);
         for (int g = 0; g < 8; g++) begin
            rd(st_addr(g), d);
            check("R1 interleave", d, (g == v % 8) ? (32'(1) << (v / 8)) : 0);
         end
         wr(st_addr(v % 8), 32'hF);
         rd(st_addr(v % 8), d); check("R2 clear all", d, 0);
      end

      // R2: partial clear (group 3, vectors 3 and 11)
      pulse(32'h0000_0808, 0, 0);
      rd(st_addr(3), d); check("R2 pre", d, 32'h3);
      wr(st_addr(3), 32'h1);
      rd(st_addr(3), d); check("R2 zero keeps", d, 32'h2);
      wr(st_addr(3), 32'hF);

      // R3: enables
      for (int g = 0; g < 8; g++) begin
         wr(st_addr(g) + 4, 32'h5);
         rd(st_addr(g) + 4, d); check("R3 set read", d, 32'h5);
         rd(st_addr(g) + 8, d); check("R3 clr read", d, 32'h5);
         wr(st_addr(g) + 8, 32'h1);
         rd(st_addr(g) + 4, d); check("R3 after clr", d, 32'h4);
         wr(st_addr(g) + 8, 32'hF);
         rd(st_addr(g) + 8, d); check("R3 all clr", d, 0);
      end

      // R4: masking on group 2 (enable bit 1 = vector 10)
      wr(st_addr(2) + 4, 32'h2);
      pulse(32'(1) << 2, 0, 0);
      check("R4 masked pending", 32'(msi_irq), 0);
      pulse(32'(1) << 10, 0, 0);
      check("R4 enabled pending", 32'(msi_irq), 32'h04);

      // R5: end of interrupt
      wr(12'h050, 32'd5);
      check("R5 other group eoi", 32'(msi_irq), 32'h04);
      wr(12'h050, 32'd6);
      check("R5 gap", 32'(msi_irq), 0);
      @(negedge clk);
      check("R5 rearm", 32'(msi_irq), 32'h04);
      wr(st_addr(2), 32'hF);
      check("R5 cleared", 32'(msi_irq), 0);
      wr(st_addr(2) + 8, 32'hF);

      // R6: legacy line 1
      wr(12'h198, 32'h1);
      pulse(0, 4'b0010, 0);
      check("R6 intx out", 32'(intx_irq), 32'h2);
      rd(12'h194, d); check("R6 intx status", d, 1);
      rd(12'h19C, d); check("R6 intx enable", d, 1);
      wr(12'h050, 32'd1);
      check("R6 intx gap", 32'(intx_irq), 0);
      @(negedge clk);
      check("R6 intx rearm", 32'(intx_irq), 32'h2);
      wr(12'h194, 32'h1);
      check("R6 intx clear", 32'(intx_irq), 0);

      // R7, R9: error views
      pulse(0, 0, 6'h3F);
      rd(12'h1C0, d); check("R7 raw", d, 32'h3F);
      rd(12'h1C4, d); check("R7 masked none", d, 0);
      check("R9 no enable", 32'({err_irq, err_fatal_irq}), 0);
      wr(12'h1C8, 32'h05);
      rd(12'h1C4, d); check("R7 masked", d, 32'h05);
      check("R9 nonfatal", 32'({err_irq, err_fatal_irq}), 32'b10);
      wr(12'h1C8, 32'h10);
      check("R9 fatal", 32'({err_irq, err_fatal_irq}), 32'b11);
      rd(12'h1CC, d); check("R7 enable read", d, 32'h15);

      // R8: raw write ignored, masked-view W1C
      wr(12'h1C0, 32'h3F);
      rd(12'h1C0, d); check("R8 raw write ignored", d, 32'h3F);
      wr(12'h1C4, 32'h10);
      rd(12'h1C0, d); check("R8 w1c", d, 32'h2F);
      check("R9 fatal gone", 32'({err_irq, err_fatal_irq}), 32'b10);
      wr(12'h1C4, 32'h3F);
      rd(12'h1C0, d); check("R8 all clear", d, 0);

      // R10: collision, set wins
      pulse(32'h1, 0, 0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = st_addr(0); reg_wdata = 32'h3; msi_hit = 32'h1;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; msi_hit = '0;
      rd(st_addr(0), d); check("R10 set wins", d, 32'h1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule